// File: doc/BRIEF.md
# Per-Processor Compare Timer Interrupt Unit

The unit keeps one shared free-running counter and, for every processor, a small bank of local registers: a control word, a pending word, an interrupt mask, a compare-to-pin routing word, an indirection index and a compare value. When the shared counter equals a processor's compare value, that processor's compare-pending bit is set. If the compare source is unmasked and its routing word has the route-enable flag set, the selected CPU interrupt pin of that processor is driven high.

Software reaches the registers over a single-cycle word-addressed register bus that carries the index of the requesting processor. A processor addresses its own bank through the local window. It addresses a peer's bank through the remote window, and the peer is the one named in the requester's indirection register. Reads are combinational and have no side effects, so the bus carries no handshake. Each pin output is the OR of the compare interrupt and an external routing input for the same processor and pin.

Top module: `lti_unit`

## Requirements
- R1: After reset every bank holds control 0, pending 0, mask 0x32, routing word 0x8000_0000, compare 0xFFFF_FFFF and indirection 0. The counter is 0 and running, and all pin outputs are low.
- R2: The identity register (bank offset 7) returns the index of the bank being accessed. Through the remote window that is the indirection target, not the requester.
- R3: Word addresses 0x10–0x1F select the requester's own bank and 0x20–0x2F select the bank named by the requester's indirection register (offset 6). A write of an indirection value not below the processor count is dropped.
- R4: The 6-bit mask (offset 2) changes only by a set write (offset 4, OR in bits [5:0]) or a clear write (offset 3, clear the bits that are 1). Mask bit 1 gates the compare interrupt.
- R5: The routing word (offset 5) has its route-enable flag in bit 31 and the pin number in bits [5:0]. A write whose pin is above the highest pin (NUM_PIN-1) is dropped.
- R6: Bit 0 of the shared configuration word (address 0x00) stops the counter when 1 and restarts it when 0. The counter (address 0x01) advances by one per cycle while running and accepts writes only while stopped.
- R7: If the counter equals the compare value (offset 8) during a cycle, pending bit 1 (offset 1) is set at the following edge. The pin selected by the routing word is high exactly while that bit is set, mask bit 1 is set and the route-enable flag is set.
- R8: A write to the compare register clears that bank's pending bit 1, and the clear takes priority over a match in the same cycle.
- R9: The counter-high word (0x02), the compare-high word (offset 9) and the control word (offset 0) read as zero, and writes to the control word are ignored. The user mirror of the counter (0x03, high word 0x04) is read-only.
- R10: Each pin output is the OR of the compare interrupt and the `ext_route` input bit at the same position. Processor v owns bits v*NUM_PIN to v*NUM_PIN+NUM_PIN-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the current bus word |
| bus_addr | input | ADDR_W | Word address |
| bus_vp | input | VPW | Index of the requesting processor |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address and state |
| ext_route | input | NUM_VP*NUM_PIN | Shared routing pin levels to merge |
| irq_pin | output | NUM_VP*NUM_PIN | Per-processor CPU pin levels |

## Verification
Read data is combinational, so the bench samples it 1 ns into the low clock phase of the cycle that presents the address. A register write is due at the rising edge that ends its cycle, and the bench reads it back on a later cycle. Pending bit 1 sets one edge after the counter reaches the compare value. For that reason the bench loads the stopped counter with the compare value and expects the pin low just after that edge and high just after the next one. Changes to mask, routing and `ext_route` reach the pins in the same cycle, and the bench checks them 1 ns after the updating edge or input change.

// File: rtl/lti_pkg.sv
package lti_pkg;
  // window offsets inside a bank
  localparam logic [3:0] OFF_CTL   = 4'd0;
  localparam logic [3:0] OFF_PEND  = 4'd1;
  localparam logic [3:0] OFF_MASK  = 4'd2;
  localparam logic [3:0] OFF_MCLR  = 4'd3;
  localparam logic [3:0] OFF_MSET  = 4'd4;
  localparam logic [3:0] OFF_ROUTE = 4'd5;
  localparam logic [3:0] OFF_INDIR = 4'd6;
  localparam logic [3:0] OFF_IDENT = 4'd7;
  localparam logic [3:0] OFF_CMPLO = 4'd8;
  localparam logic [3:0] OFF_CMPHI = 4'd9;
  // shared words
  localparam logic [3:0] SH_CFG    = 4'd0;
  localparam logic [3:0] SH_CNTLO  = 4'd1;
  localparam logic [3:0] SH_CNTHI  = 4'd2;
  localparam logic [3:0] SH_USRLO  = 4'd3;
  localparam logic [3:0] SH_USRHI  = 4'd4;
  // window selector, address bits [5:4]
  localparam logic [1:0] WIN_SHARED = 2'd0;
  localparam logic [1:0] WIN_LOCAL  = 2'd1;
  localparam logic [1:0] WIN_REMOTE = 2'd2;
  // field layout
  localparam int MASK_W      = 6;
  localparam logic [MASK_W-1:0] MASK_RST = 6'h32;
  localparam int CMP_BIT     = 1;
  localparam int ROUTE_FLAG  = 31;
  localparam int ROUTE_PIN_W = 6;
endpackage

// File: rtl/lti_counter.sv
module lti_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             stop_in,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic             stop_q,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (cfg_we) stop_q <= stop_in;
      if (stop_q) begin
        if (cnt_we) cnt_q <= cnt_wdata;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R6: running counter advances by exactly one, writes have no effect
  p_run_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_q |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  // R6: stopped counter only moves through a write
  p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !cnt_we) |=> $stable(cnt_q));
endmodule

// File: rtl/lti_decode.sv
module lti_decode #(
  parameter int NUM_VP = 4,
  parameter int VPW    = 2,
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [VPW-1:0]        req_vp,
  input  logic [NUM_VP*VPW-1:0] indir_flat,
  output logic                  sh_hit,
  output logic                  bank_hit,
  output logic [VPW-1:0]        bank_idx,
  output logic [3:0]            off
);
  import lti_pkg::*;
  logic [1:0] win;
  logic       vp_ok;

  assign win   = addr[5:4];
  assign off   = addr[3:0];
  assign vp_ok = 32'(req_vp) < NUM_VP;

  always_comb begin
    sh_hit   = (win == WIN_SHARED) && (ADDR_W == 6 || addr[ADDR_W-1:6] == '0);
    bank_hit = 1'b0;
    bank_idx = req_vp;
    if (vp_ok && (ADDR_W == 6 || addr[ADDR_W-1:6] == '0)) begin
      if (win == WIN_LOCAL) begin
        bank_hit = 1'b1;
      end else if (win == WIN_REMOTE) begin
        bank_hit = 1'b1;
        bank_idx = indir_flat[req_vp*VPW +: VPW];
      end
    end
  end
endmodule

// File: rtl/lti_bank.sv
module lti_bank #(
  parameter int NUM_VP  = 4,
  parameter int NUM_PIN = 6,
  parameter int CNT_W   = 32,
  parameter int VPW     = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [3:0]                          wr_off,
  input  logic [31:0]                         wr_data,
  input  logic [CNT_W-1:0]                    cnt,
  output logic                                cmp_pend,
  output logic [lti_pkg::MASK_W-1:0]          mask_q,
  output logic                                route_en_q,
  output logic [lti_pkg::ROUTE_PIN_W-1:0]     route_pin_q,
  output logic [VPW-1:0]                      indir_q,
  output logic [CNT_W-1:0]                    cmp_q,
  output logic [NUM_PIN-1:0]                  pin_o
);
  import lti_pkg::*;
  logic wr_cmp, wr_route_ok, wr_indir_ok;

  assign wr_cmp      = wr_en && (wr_off == OFF_CMPLO);
  assign wr_route_ok = wr_en && (wr_off == OFF_ROUTE) &&
                       (32'(wr_data[ROUTE_PIN_W-1:0]) < NUM_PIN);
  assign wr_indir_ok = wr_en && (wr_off == OFF_INDIR) && (wr_data < 32'(NUM_VP));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_pend    <= 1'b0;
      mask_q      <= MASK_RST;
      route_en_q  <= 1'b1;
      route_pin_q <= '0;
      indir_q     <= '0;
      cmp_q       <= '1;
    end else begin
      if (wr_cmp)                    cmp_pend <= 1'b0;
      else if (cnt == cmp_q)         cmp_pend <= 1'b1;
      if (wr_cmp)                    cmp_q <= wr_data[CNT_W-1:0];
      if (wr_en && wr_off == OFF_MCLR) mask_q <= mask_q & ~wr_data[MASK_W-1:0];
      if (wr_en && wr_off == OFF_MSET) mask_q <= mask_q | wr_data[MASK_W-1:0];
      if (wr_route_ok) begin
        route_en_q  <= wr_data[ROUTE_FLAG];
        route_pin_q <= wr_data[ROUTE_PIN_W-1:0];
      end
      if (wr_indir_ok)               indir_q <= wr_data[VPW-1:0];
    end
  end

  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
    assign pin_o[p] = cmp_pend && mask_q[CMP_BIT] && route_en_q &&
                      (route_pin_q == ROUTE_PIN_W'(p));
  end

  // R8: compare write always leaves the pending bit clear
  p_cmp_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmp |=> !cmp_pend);
  // R7: equality sets the pending bit one edge later
  p_match_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == cmp_q && !wr_cmp) |=> cmp_pend);
  // R7: at most one pin of a bank is driven by its compare source
  p_pin_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pin_o));
  // R3: indirection never names a missing bank
  p_indir_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(indir_q) < NUM_VP);
  // R5: stored pin always exists
  p_route_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(route_pin_q) < NUM_PIN);
  // R4: mask is untouched by cycles without a write to this bank
  p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_q));
endmodule

// File: rtl/lti_unit.sv
module lti_unit #(
  parameter int NUM_VP  = 4,
  parameter int NUM_PIN = 6,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 6,
  localparam int VPW    = (NUM_VP > 1) ? $clog2(NUM_VP) : 1,
  localparam int PINS   = NUM_VP * NUM_PIN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [VPW-1:0]    bus_vp,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [PINS-1:0]   ext_route,
  output logic [PINS-1:0]   irq_pin
);
  import lti_pkg::*;

  logic                   stop_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   sh_hit, bank_hit;
  logic [VPW-1:0]         bank_idx;
  logic [3:0]             off;
  logic [NUM_VP*VPW-1:0]  indir_flat;

  logic                   pend_a  [NUM_VP];
  logic [MASK_W-1:0]      mask_a  [NUM_VP];
  logic                   ren_a   [NUM_VP];
  logic [ROUTE_PIN_W-1:0] rpin_a  [NUM_VP];
  logic [VPW-1:0]         indir_a [NUM_VP];
  logic [CNT_W-1:0]       cmp_a   [NUM_VP];
  logic [NUM_PIN-1:0]     pin_a   [NUM_VP];

  lti_decode #(.NUM_VP(NUM_VP), .VPW(VPW), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .req_vp(bus_vp), .indir_flat(indir_flat),
    .sh_hit(sh_hit), .bank_hit(bank_hit), .bank_idx(bank_idx), .off(off));

  lti_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(bus_we && sh_hit && off == SH_CFG), .stop_in(bus_wdata[0]),
    .cnt_we(bus_we && sh_hit && off == SH_CNTLO), .cnt_wdata(bus_wdata[CNT_W-1:0]),
    .stop_q(stop_q), .cnt_q(cnt_q));

  for (genvar g = 0; g < NUM_VP; g++) begin : g_bank
    lti_bank #(.NUM_VP(NUM_VP), .NUM_PIN(NUM_PIN), .CNT_W(CNT_W), .VPW(VPW)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_we && bank_hit && bank_idx == VPW'(g)),
      .wr_off(off), .wr_data(bus_wdata), .cnt(cnt_q),
      .cmp_pend(pend_a[g]), .mask_q(mask_a[g]), .route_en_q(ren_a[g]),
      .route_pin_q(rpin_a[g]), .indir_q(indir_a[g]), .cmp_q(cmp_a[g]),
      .pin_o(pin_a[g]));
    assign indir_flat[g*VPW +: VPW]     = indir_a[g];
    assign irq_pin[g*NUM_PIN +: NUM_PIN] = pin_a[g] | ext_route[g*NUM_PIN +: NUM_PIN];
  end

  always_comb begin
    bus_rdata = '0;
    if (sh_hit) begin
      case (off)
        SH_CFG:             bus_rdata = (32'(NUM_VP) << 8) | 32'(stop_q);
        SH_CNTLO, SH_USRLO: bus_rdata = 32'(cnt_q);
        default:            bus_rdata = '0;
      endcase
    end else if (bank_hit) begin
      case (off)
        OFF_PEND:  bus_rdata = 32'(pend_a[bank_idx]) << CMP_BIT;
        OFF_MASK:  bus_rdata = 32'(mask_a[bank_idx]);
        OFF_ROUTE: bus_rdata = {ren_a[bank_idx], 25'b0, rpin_a[bank_idx]};
        OFF_INDIR: bus_rdata = 32'(indir_a[bank_idx]);
        OFF_IDENT: bus_rdata = 32'(bank_idx);
        OFF_CMPLO: bus_rdata = 32'(cmp_a[bank_idx]);
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R10: an asserted routing input always shows on its pin
  p_route_or_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pin & ext_route) == ext_route);
  // R9: the user mirror never writes the counter
  p_user_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sh_hit && off == SH_USRLO && stop_q) |=> $stable(cnt_q));
endmodule

// File: tb/tb_lti_unit.sv
module tb_lti_unit;
  localparam int NUM_VP = 4, NUM_PIN = 6, PINS = 24;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [1:0]  bus_vp = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [PINS-1:0] ext_route = '0;
  logic [PINS-1:0] irq_pin;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lti_unit dut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_vp(bus_vp), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_route(ext_route), .irq_pin(irq_pin));

  // {req, we, addr, vp, wdata, expected}
  localparam int NV = 28;
  localparam logic [76:0] VEC [NV] = '{
    {4'd2, 1'b0, 6'h17, 2'd2, 32'h0, 32'h2},          // R2 ident local
    {4'd1, 1'b0, 6'h12, 2'd0, 32'h0, 32'h32},         // R1 mask reset
    {4'd1, 1'b0, 6'h15, 2'd1, 32'h0, 32'h8000_0000},  // R1 route reset
    {4'd1, 1'b0, 6'h18, 2'd3, 32'h0, 32'hFFFF_FFFF},  // R1 compare reset
    {4'd1, 1'b0, 6'h11, 2'd0, 32'h0, 32'h0},          // R1 pending reset
    {4'd1, 1'b0, 6'h16, 2'd0, 32'h0, 32'h0},          // R1 indirection reset
    {4'd4, 1'b1, 6'h14, 2'd0, 32'h1, 32'h0},
    {4'd4, 1'b0, 6'h12, 2'd0, 32'h0, 32'h33},         // R4 set
    {4'd4, 1'b1, 6'h13, 2'd0, 32'h30, 32'h0},
    {4'd4, 1'b0, 6'h12, 2'd0, 32'h0, 32'h03},         // R4 clear
    {4'd3, 1'b1, 6'h16, 2'd0, 32'h3, 32'h0},
    {4'd3, 1'b0, 6'h16, 2'd0, 32'h0, 32'h3},          // R3 indirection
    {4'd2, 1'b0, 6'h27, 2'd0, 32'h0, 32'h3},          // R2 ident remote
    {4'd3, 1'b1, 6'h24, 2'd0, 32'h08, 32'h0},
    {4'd3, 1'b0, 6'h12, 2'd3, 32'h0, 32'h3A},         // R3 remote hit bank 3
    {4'd3, 1'b0, 6'h12, 2'd0, 32'h0, 32'h03},         // R3 own bank untouched
    {4'd3, 1'b1, 6'h16, 2'd1, 32'h4, 32'h0},
    {4'd3, 1'b0, 6'h16, 2'd1, 32'h0, 32'h0},          // R3 out-of-range dropped
    {4'd5, 1'b1, 6'h15, 2'd2, 32'h8000_0006, 32'h0},
    {4'd5, 1'b0, 6'h15, 2'd2, 32'h0, 32'h8000_0000},  // R5 bad pin dropped
    {4'd5, 1'b1, 6'h15, 2'd2, 32'h8000_0004, 32'h0},
    {4'd5, 1'b0, 6'h15, 2'd2, 32'h0, 32'h8000_0004},  // R5 accepted
    {4'd9, 1'b1, 6'h10, 2'd1, 32'hFF, 32'h0},
    {4'd9, 1'b0, 6'h10, 2'd1, 32'h0, 32'h0},          // R9 control
    {4'd9, 1'b0, 6'h19, 2'd1, 32'h0, 32'h0},          // R9 compare high
    {4'd9, 1'b0, 6'h02, 2'd0, 32'h0, 32'h0},          // R9 counter high
    {4'd9, 1'b0, 6'h04, 2'd0, 32'h0, 32'h0},          // R9 user high
    {4'd6, 1'b0, 6'h00, 2'd0, 32'h0, 32'h400}         // R6 config running
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [1:0] v, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_vp = v; bus_wdata = d;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [1:0] v, output logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a; bus_vp = v;
    #1 d = bus_rdata;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1 chk(irq_pin == '0, "R1", 32'(irq_pin), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:66], VEC[i][65:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][71:66], VEC[i][65:64], a);
        chk(a == VEC[i][31:0], $sformatf("R%0d vec %0d", VEC[i][76:73], i), a, VEC[i][31:0]);
      end
    end

    // R6: running, stop, write only while stopped; R9 user mirror read-only
    rd(6'h01, 2'd0, a); rd(6'h01, 2'd0, b);
    chk(b == a + 1, "R6 running", b, a + 1);
    wr(6'h00, 2'd0, 32'h1);
    rd(6'h01, 2'd0, a); rd(6'h01, 2'd0, b);
    chk(a == b, "R6 stopped", b, a);
    wr(6'h01, 2'd0, 32'd100);
    rd(6'h01, 2'd0, a);
    chk(a == 32'd100, "R6 write stopped", a, 32'd100);
    wr(6'h03, 2'd0, 32'd5);
    rd(6'h03, 2'd0, a);
    chk(a == 32'd100, "R9 user mirror", a, 32'd100);
    wr(6'h00, 2'd0, 32'h0);
    wr(6'h01, 2'd0, 32'd7);
    rd(6'h01, 2'd0, a);
    chk(a > 32'd100, "R6 write while running", a, 32'd101);

    // R7: compare match on vp1 pin 2 (irq bit 8)
    wr(6'h00, 2'd0, 32'h1);
    wr(6'h01, 2'd0, 32'd50);
    wr(6'h15, 2'd1, 32'h8000_0002);
    wr(6'h18, 2'd1, 32'd53);
    wr(6'h01, 2'd0, 32'd53);
    chk(irq_pin[8] == 1'b0, "R7 not before next edge", 32'(irq_pin[8]), 32'h0);
    @(posedge clk); #1;
    chk(irq_pin == 24'h100, "R7 pin raised", 32'(irq_pin), 32'h100);
    rd(6'h11, 2'd1, a);
    chk(a == 32'h2, "R7 pending", a, 32'h2);
    wr(6'h13, 2'd1, 32'h2);
    chk(irq_pin[8] == 1'b0, "R4 masked", 32'(irq_pin[8]), 32'h0);
    rd(6'h11, 2'd1, a);
    chk(a == 32'h2, "R4 pending kept", a, 32'h2);
    wr(6'h14, 2'd1, 32'h2);
    chk(irq_pin[8] == 1'b1, "R4 unmasked", 32'(irq_pin[8]), 32'h1);

    // R8: compare write clears
    wr(6'h18, 2'd1, 32'd200);
    chk(irq_pin[8] == 1'b0, "R8 pin cleared", 32'(irq_pin[8]), 32'h0);
    rd(6'h11, 2'd1, a);
    chk(a == 32'h0, "R8 pending cleared", a, 32'h0);

    // R7: without route flag no pin
    wr(6'h15, 2'd1, 32'h2);
    wr(6'h01, 2'd0, 32'd200);
    @(posedge clk); #1;
    rd(6'h11, 2'd1, a);
    chk(a == 32'h2, "R7 pending no flag", a, 32'h2);
    chk(irq_pin == '0, "R7 no flag pin low", 32'(irq_pin), 32'h0);

    // R10: external routing merge
    @(negedge clk); ext_route = 24'h20;
    #1 chk(irq_pin == 24'h20, "R10 merge", 32'(irq_pin), 32'h20);
    ext_route = '0;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule